// File: doc/BRIEF.md
# Serial Bus Device ID Search Engine

This block finds every device hanging on a single-wire open-drain bus by walking a binary tree over their 64-bit identifiers. Each pass starts by asking a command layer to send the bus reset and the search command. After that, for each of the 64 bit positions, the engine requests two read slots and one write slot from a slot generator. The two reads return the wired-AND of every still-active device's ID bit and then the wired-AND of its complement. The write sends back the branch the engine picked, and devices that disagree with it drop out until the next pass.

Each pass produces one identifier. The engine presents it with a one-cycle strobe, along with a flag saying whether its CRC-8 checks out. It remembers the identifier and the highest position where it took the zero side of a conflict, and uses both to steer the next pass onto the branch it has not yet explored. The search ends normally once a pass takes no zero branch. It aborts with an error code if the bus stops answering too often in a row, or if the number of passes exceeds a fixed ceiling.

Top module: `ow_rom_search`

## Requirements
- R1: While reset is asserted, and afterwards until `start` is seen, `busy`, `done`, `cmd_req`, `slot_req` and `id_valid` are all low.
- R2: Each pass opens with `cmd_req` held until `cmd_ack`. For a search that ends with code 0, the number of command handshakes equals the number of IDs times one plus the no-response restarts taken in each pass.
- R3: At each bit position the engine takes a read slot (`slot_wr`=0), then a second read slot, then one write slot (`slot_wr`=1) that carries the chosen direction on `slot_wbit`. A slot request and its direction stay stable until `slot_done`.
- R4: When both reads return 0 (a conflict), the engine picks a direction as follows. Below the previous zero-branch position it reuses the previous ID's bit. At that exact position it picks 1. Above it, or when no previous zero-branch position exists, it picks 0. As a result, distinct IDs come out in ascending order of their bit-reversed value (bit 0 is most significant), each one exactly once.
- R5: A read pair of 1 then 0 forces direction 1, and a pair of 0 then 1 forces direction 0. A lone device is reported with its exact ID in one pass.
- R6: A read pair of 1 and 1 means no response. The pass restarts from the command step. Up to MAX_RETRY (5) restarts in a row are tolerated. One more ends the search with `err_code`=1.
- R7: The restart counter clears when a pass completes, so each pass may use the full MAX_RETRY restarts.
- R8: The search ends with `done` and `err_code`=0 after a pass that took no zero branch. Every device is reported by then.
- R9: If a further pass is needed after MAX_PASS (11) passes have completed, the search ends with `err_code`=2. Exactly MAX_PASS IDs have been reported by then.
- R10: `id_crc_ok` is 1 when a CRC-8 register that starts at 0 and takes all 64 ID bits, bit 0 first, ends at 0. The CRC is the reflected polynomial x^8+x^5+x^4+1, with shift constant 0x8C.
- R11: `id_valid` and `done` are one-cycle strobes. `busy` is high from the cycle after `start` through `done` and falls in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a new search when idle |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search strobe |
| err_code | output | 2 | Result code valid with `done`: 0 complete, 1 no response, 2 pass limit |
| cmd_req | output | 1 | Request bus reset plus search command |
| cmd_ack | input | 1 | Command step finished |
| slot_req | output | 1 | Request one bit slot |
| slot_wr | output | 1 | 1 = write slot, 0 = read slot |
| slot_wbit | output | 1 | Bit to write in a write slot |
| slot_done | input | 1 | Slot finished; `slot_rbit` valid in this cycle |
| slot_rbit | input | 1 | Bit sampled in a read slot |
| id_out | output | ID_W | Identifier found by the pass, bit 0 first on the bus |
| id_valid | output | 1 | One-cycle strobe for `id_out` |
| id_crc_ok | output | 1 | CRC check result for `id_out`, valid with `id_valid` |

## Verification
The hardest states to reach from the ports are the retry limits. An exact run of no-response pairs is needed, either spread over several passes or piling up inside one pass. The pass ceiling also needs more devices than passes allowed. The bench drives a behavioural bus of twelve devices that computes the wired-AND itself and drops devices on mismatched writes. It can force a set number of both-ones pairs at one bit position in every pass, and a table of device subsets and dropout counts takes the engine to each limit and to one step short of it.

// File: rtl/ow_srch_pkg.sv
package ow_srch_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CMD,
    S_RD_BIT,
    S_RD_CMP,
    S_WRITE,
    S_REPORT,
    S_FINISH
  } srch_state_e;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'd0,
    ERR_NORESP = 2'd1,
    ERR_PASSES = 2'd2
  } srch_err_e;

endpackage

// File: rtl/ow_crc8.sv
module ow_crc8 #(
  parameter int          CRC_W = 8,
  parameter logic [CRC_W-1:0] POLY_R = 8'h8C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             din,
  output logic [CRC_W-1:0] crc
);
  logic [CRC_W-1:0] crc_q, crc_d;
  logic             fb;

  always_comb begin
    fb    = crc_q[0] ^ din;
    crc_d = crc_q;
    if (clr) begin
      crc_d = '0;
    end else if (en) begin
      crc_d = (crc_q >> 1) ^ (fb ? POLY_R : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;
endmodule

// File: rtl/ow_branch_sel.sv
module ow_branch_sel #(
  parameter int POS_W = 6
) (
  input  logic             rd_bit,
  input  logic             rd_cmp,
  input  logic [POS_W-1:0] pos,
  input  logic             prior_vld,
  input  logic [POS_W-1:0] prior_pos,
  input  logic             prev_bit,
  output logic             dir,
  output logic             conflict,
  output logic             no_resp
);
  always_comb begin
    conflict = !rd_bit && !rd_cmp;
    no_resp  = rd_bit && rd_cmp;
    dir      = rd_bit;
    if (conflict) begin
      if (prior_vld && (pos < prior_pos)) dir = prev_bit;
      else                                dir = prior_vld && (pos == prior_pos);
    end
  end
endmodule

// File: rtl/ow_lim_cnt.sv
module ow_lim_cnt #(
  parameter int LIMIT = 5,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_lim
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                   cnt_d = '0;
    else if (inc && !at_lim)   cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign at_lim = (cnt_q == W'(LIMIT));
endmodule

// File: rtl/ow_rom_search.sv
module ow_rom_search
  import ow_srch_pkg::*;
#(
  parameter int ID_W      = 64,
  parameter int MAX_RETRY = 5,
  parameter int MAX_PASS  = 11,
  localparam int POS_W    = $clog2(ID_W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            busy,
  output logic            done,
  output logic [1:0]      err_code,
  output logic            cmd_req,
  input  logic            cmd_ack,
  output logic            slot_req,
  output logic            slot_wr,
  output logic            slot_wbit,
  input  logic            slot_done,
  input  logic            slot_rbit,
  output logic [ID_W-1:0] id_out,
  output logic            id_valid,
  output logic            id_crc_ok
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(ID_W - 1);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  srch_state_e      state_q, state_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic             bit_q, bit_d;
  logic             dir_q, dir_d;
  logic [ID_W-1:0]  probed_q, probed_d;
  logic [ID_W-1:0]  prev_q, prev_d;
  logic             pvld_q, pvld_d;
  logic [POS_W-1:0] ppos_q, ppos_d;
  logic             lvld_q, lvld_d;
  logic [POS_W-1:0] lpos_q, lpos_d;
  srch_err_e        err_q, err_d;

  logic       crc_clr, crc_en;
  logic [7:0] crc;
  logic       rty_clr, rty_inc, rty_at_lim;
  logic       pass_clr, pass_inc, pass_at_lim;
  logic       sel_dir, sel_conflict, sel_none;

  ow_branch_sel #(.POS_W(POS_W)) i_sel (
    .rd_bit    (bit_q),
    .rd_cmp    (slot_rbit),
    .pos       (pos_q),
    .prior_vld (pvld_q),
    .prior_pos (ppos_q),
    .prev_bit  (prev_q[pos_q]),
    .dir       (sel_dir),
    .conflict  (sel_conflict),
    .no_resp   (sel_none)
  );

  ow_crc8 i_crc (
    .clk   (clk),
    .rst_n (rst_i),
    .clr   (crc_clr),
    .en    (crc_en),
    .din   (dir_q),
    .crc   (crc)
  );

  ow_lim_cnt #(.LIMIT(MAX_RETRY)) i_rty (
    .clk    (clk),
    .rst_n  (rst_i),
    .clr    (rty_clr),
    .inc    (rty_inc),
    .at_lim (rty_at_lim)
  );

  ow_lim_cnt #(.LIMIT(MAX_PASS - 1)) i_pass (
    .clk    (clk),
    .rst_n  (rst_i),
    .clr    (pass_clr),
    .inc    (pass_inc),
    .at_lim (pass_at_lim)
  );

  always_comb begin
    state_d  = state_q;
    pos_d    = pos_q;
    bit_d    = bit_q;
    dir_d    = dir_q;
    probed_d = probed_q;
    prev_d   = prev_q;
    pvld_d   = pvld_q;
    ppos_d   = ppos_q;
    lvld_d   = lvld_q;
    lpos_d   = lpos_q;
    err_d    = err_q;
    crc_clr  = 1'b0;
    crc_en   = 1'b0;
    rty_clr  = 1'b0;
    rty_inc  = 1'b0;
    pass_clr = 1'b0;
    pass_inc = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (start) begin
          pvld_d   = 1'b0;
          ppos_d   = '0;
          prev_d   = '0;
          pass_clr = 1'b1;
          rty_clr  = 1'b1;
          err_d    = ERR_NONE;
          state_d  = S_CMD;
        end
      end
      S_CMD: begin
        if (cmd_ack) begin
          pos_d    = '0;
          probed_d = '0;
          lvld_d   = 1'b0;
          lpos_d   = '0;
          crc_clr  = 1'b1;
          state_d  = S_RD_BIT;
        end
      end
      S_RD_BIT: begin
        if (slot_done) begin
          bit_d   = slot_rbit;
          state_d = S_RD_CMP;
        end
      end
      S_RD_CMP: begin
        if (slot_done) begin
          if (sel_none) begin
            if (rty_at_lim) begin
              err_d   = ERR_NORESP;
              state_d = S_FINISH;
            end else begin
              rty_inc = 1'b1;
              state_d = S_CMD;
            end
          end else begin
            dir_d = sel_dir;
            if (sel_conflict && !sel_dir) begin
              lvld_d = 1'b1;
              lpos_d = pos_q;
            end
            state_d = S_WRITE;
          end
        end
      end
      S_WRITE: begin
        if (slot_done) begin
          probed_d[pos_q] = dir_q;
          crc_en          = 1'b1;
          if (pos_q == LAST_POS) begin
            state_d = S_REPORT;
          end else begin
            pos_d   = pos_q + POS_W'(1);
            state_d = S_RD_BIT;
          end
        end
      end
      S_REPORT: begin
        prev_d  = probed_q;
        pvld_d  = lvld_q;
        ppos_d  = lpos_q;
        rty_clr = 1'b1;
        if (!lvld_q) begin
          state_d = S_FINISH;
        end else if (pass_at_lim) begin
          err_d   = ERR_PASSES;
          state_d = S_FINISH;
        end else begin
          pass_inc = 1'b1;
          state_d  = S_CMD;
        end
      end
      S_FINISH: state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q  <= S_IDLE;
      pos_q    <= '0;
      bit_q    <= 1'b0;
      dir_q    <= 1'b0;
      probed_q <= '0;
      prev_q   <= '0;
      pvld_q   <= 1'b0;
      ppos_q   <= '0;
      lvld_q   <= 1'b0;
      lpos_q   <= '0;
      err_q    <= ERR_NONE;
    end else begin
      state_q  <= state_d;
      pos_q    <= pos_d;
      bit_q    <= bit_d;
      dir_q    <= dir_d;
      probed_q <= probed_d;
      prev_q   <= prev_d;
      pvld_q   <= pvld_d;
      ppos_q   <= ppos_d;
      lvld_q   <= lvld_d;
      lpos_q   <= lpos_d;
      err_q    <= err_d;
    end
  end

  assign busy      = (state_q != S_IDLE);
  assign done      = (state_q == S_FINISH);
  assign err_code  = err_q;
  assign cmd_req   = (state_q == S_CMD);
  assign slot_req  = (state_q == S_RD_BIT) || (state_q == S_RD_CMP) || (state_q == S_WRITE);
  assign slot_wr   = (state_q == S_WRITE);
  assign slot_wbit = (state_q == S_WRITE) && dir_q;
  assign id_valid  = (state_q == S_REPORT);
  assign id_out    = probed_q;
  assign id_crc_ok = id_valid && (crc == 8'h00);
endmodule

// File: rtl/ow_rom_search_chk.sv
module ow_rom_search_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic cmd_req,
  input logic slot_req,
  input logic slot_wr,
  input logic slot_wbit,
  input logic slot_done,
  input logic id_valid
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cmd_req && !slot_req && !id_valid));

  p_slot_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req && !slot_done) |=> (slot_req && $stable(slot_wr) && $stable(slot_wbit)));

  p_read_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req && slot_wr && slot_done) |=> !slot_wr);

  p_report_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |-> (busy && !slot_req && !cmd_req));

  p_valid_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |=> !id_valid);

  p_done_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done));
endmodule

bind ow_rom_search ow_rom_search_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .cmd_req   (cmd_req),
  .slot_req  (slot_req),
  .slot_wr   (slot_wr),
  .slot_wbit (slot_wbit),
  .slot_done (slot_done),
  .id_valid  (id_valid)
);

// File: tb/test_ow_rom_search.sv
`timescale 1ns/1ps
module test_ow_rom_search;
  localparam int ID_W = 64, MAX_RETRY = 5, MAX_PASS = 11, NDEV = 12, NSCEN = 8;
  localparam int DROP_POS = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst_n = 1'b0, start = 1'b0;
  logic            busy, done, cmd_req, slot_req, slot_wr, slot_wbit, id_valid, id_crc_ok;
  logic [1:0]      err_code;
  logic            cmd_ack = 1'b0, slot_done = 1'b0, slot_rbit = 1'b0;
  logic [ID_W-1:0] id_out;

  ow_rom_search #(.ID_W(ID_W), .MAX_RETRY(MAX_RETRY), .MAX_PASS(MAX_PASS)) i_ow_rom_search (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .err_code(err_code),
    .cmd_req(cmd_req), .cmd_ack(cmd_ack), .slot_req(slot_req), .slot_wr(slot_wr),
    .slot_wbit(slot_wbit), .slot_done(slot_done), .slot_rbit(slot_rbit),
    .id_out(id_out), .id_valid(id_valid), .id_crc_ok(id_crc_ok)
  );

  // 56-bit bodies; the CRC byte is computed on top, device 3 gets a corrupted one
  localparam logic [55:0] BODY [NDEV] = '{
    56'h0000_1234_5678_28, 56'h0000_1234_5679_28, 56'h00A1_B2C3_D4E5_10,
    56'h0000_0000_0001_28, 56'h0F0F_0F0F_0F0F_22, 56'hFFFF_FFFF_FFFE_01,
    56'h8000_0000_0000_28, 56'h0000_1234_5678_3B, 56'h5555_AAAA_5555_26,
    56'hABCD_EF01_2345_10, 56'h0000_0000_0000_05, 56'h7654_3210_FEDC_28 };

  // {device mask, no-response pairs per pass, expected result code}
  localparam logic [17:0] SCEN [NSCEN] = '{
    {12'h001, 4'd0, 2'd0},
    {12'h00F, 4'd0, 2'd0},
    {12'h0A5, 4'd3, 2'd0},
    {12'h003, 4'd5, 2'd0},
    {12'h011, 4'd6, 2'd1},
    {12'h000, 4'd0, 2'd1},
    {12'hFFF, 4'd0, 2'd2},
    {12'h7FF, 4'd0, 2'd0} };

  logic [63:0]     dev_id [NDEV];
  logic [NDEV-1:0] act, mask;
  int              mpos, drop_left, drop_cfg, cmd_cnt;
  bit              rphase, dropping;
  logic [63:0]     rec_id [16];
  logic            rec_ok [16];
  int              rec_n;
  bit              done_seen;
  logic [1:0]      done_err;
  int              checks = 0, fails = 0;
  bit              finished = 1'b0;

  function automatic logic [7:0] crc_of(input logic [63:0] v, input int n);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < n; i++) begin
      logic fb = c[0] ^ v[i];
      c = c >> 1;
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  function automatic logic [63:0] rev64(input logic [63:0] v);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = v[63-i];
    return r;
  endfunction

  function automatic logic wired_and(input bit cmp);
    logic r = 1'b1;
    for (int d = 0; d < NDEV; d++)
      if (act[d] && mpos < 64) r = r & (dev_id[d][mpos] ^ cmp);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] actual, input logic [63:0] expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, actual, expected);
    end
  endtask

  // bus model and monitor, acting on falling edges only
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        cmd_ack = 1'b0;
        slot_done = 1'b0;
      end else begin
        if (cmd_ack) cmd_ack = 1'b0;
        else if (cmd_req) begin
          act = mask; mpos = 0; rphase = 1'b0; dropping = 1'b0;
          cmd_cnt++;
          cmd_ack = 1'b1;
        end
        if (slot_done) slot_done = 1'b0;
        else if (slot_req) begin
          if (slot_wr) begin
            for (int d = 0; d < NDEV; d++)
              if (act[d] && mpos < 64 && dev_id[d][mpos] != slot_wbit) act[d] = 1'b0;
            mpos++;
          end else if (!rphase) begin
            if (mpos == DROP_POS && drop_left > 0) begin
              dropping = 1'b1;
              drop_left--;
            end
            slot_rbit = dropping | wired_and(1'b0);
            rphase = 1'b1;
          end else begin
            slot_rbit = dropping | wired_and(1'b1);
            rphase = 1'b0;
          end
          slot_done = 1'b1;
        end
        if (id_valid) begin
          if (rec_n < 16) begin
            rec_id[rec_n] = id_out;
            rec_ok[rec_n] = id_crc_ok;
          end
          rec_n++;
          drop_left = drop_cfg;
        end
        if (done) begin
          done_seen = 1'b1;
          done_err  = err_code;
        end
      end
    end
  end

  task automatic run_search(input int idx);
    logic [63:0] exp_id [NDEV];
    int          n, exp_n, exp_cmd;
    logic [1:0]  exp_err;
    int          drop;
    bit          hung;
    string       tag;
    mask      = SCEN[idx][17:6];
    drop      = int'(SCEN[idx][5:2]);
    exp_err   = SCEN[idx][1:0];
    drop_cfg  = drop;
    drop_left = drop;
    rec_n     = 0;
    cmd_cnt   = 0;
    done_seen = 1'b0;
    n = 0;
    for (int d = 0; d < NDEV; d++)
      if (mask[d]) begin exp_id[n] = dev_id[d]; n++; end
    for (int a = 0; a < n; a++)
      for (int b = a + 1; b < n; b++)
        if (rev64(exp_id[b]) < rev64(exp_id[a])) begin
          logic [63:0] t = exp_id[a];
          exp_id[a] = exp_id[b];
          exp_id[b] = t;
        end
    exp_n   = (exp_err == 2'd1) ? 0 : (exp_err == 2'd2) ? MAX_PASS : n;
    exp_cmd = n * (1 + drop);
    tag = (idx == 0) ? "R5" : (idx == 3) ? "R7" : (exp_err == 2'd1) ? "R6" : (exp_err == 2'd2) ? "R9" : "R8";

    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, "R11 busy after start", 64'(busy), 64'd1);
    hung = 1'b1;
    for (int c = 0; c < 30000; c++) begin
      @(negedge clk);
      if (done_seen) begin hung = 1'b0; break; end
    end
    check(!hung, {tag, " search ends"}, 64'(hung), 64'd0);
    @(negedge clk);
    check(busy == 1'b0, "R11 busy falls after done", 64'(busy), 64'd0);
    check(done_err == exp_err, {tag, " result code"}, 64'(done_err), 64'(exp_err));
    check(rec_n == exp_n, {tag, " ID count"}, 64'(rec_n), 64'(exp_n));
    for (int k = 0; k < exp_n && k < rec_n && k < 16; k++) begin
      check(rec_id[k] == exp_id[k], "R4 ID order and value", rec_id[k], exp_id[k]);
      check(rec_ok[k] == (crc_of(exp_id[k], 64) == 8'h00), "R10 CRC flag",
            64'(rec_ok[k]), 64'(crc_of(exp_id[k], 64) == 8'h00));
    end
    if (exp_err == 2'd0)
      check(cmd_cnt == exp_cmd, "R2 command handshakes", 64'(cmd_cnt), 64'(exp_cmd));
    if (idx == 0)
      check(act[0] == 1'b1, "R3 written directions kept device selected", 64'(act[0]), 64'd1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int d = 0; d < NDEV; d++) begin
      dev_id[d] = {crc_of({8'h00, BODY[d]}, 56), BODY[d]};
      if (d == 3) dev_id[d][56] = ~dev_id[d][56];
    end
    mask = '0; act = '0; drop_cfg = 0; drop_left = 0; rec_n = 0; cmd_cnt = 0;
    mpos = 0; rphase = 1'b0; dropping = 1'b0; done_seen = 1'b0; done_err = 2'd0;

    repeat (3) @(negedge clk);
    check(!busy && !done && !cmd_req && !slot_req && !id_valid, "R1 outputs in reset",
          {59'd0, busy, done, cmd_req, slot_req, id_valid}, 64'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!busy && !cmd_req && !slot_req, "R1 idle after reset release",
          {61'd0, busy, cmd_req, slot_req}, 64'd0);

    for (int s = 0; s < NSCEN; s++) run_search(s);

    // reset in the middle of a search
    mask = 12'h00F; drop_cfg = 0; drop_left = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (300) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!busy && !cmd_req && !slot_req && !id_valid, "R1 reset aborts search",
          {60'd0, busy, cmd_req, slot_req, id_valid}, 64'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!busy && !done, "R1 stays idle without start", {62'd0, busy, done}, 64'd0);
    run_search(1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule